// File: doc/BRIEF.md
# Kernel Stack Limit Checker

This block watches every data write that a 16-bit minicomputer CPU makes through its stack pointer and sorts it into one of three classes: an ordinary write, a yellow-zone warning, or a red-zone fatal stack error. A yellow write is allowed to complete and then leaves a trap request pending for the trap logic to take. A red write is aborted in the same cycle. In the following cycle the block asks for an emergency stack: the stack pointer is forced to 4, and the PC is saved together with a zero PSW placeholder.

Only kernel-mode writes through register 6 that use addressing modes 1, 2, 4 or 6 are checked. A configuration pin can further limit the check to register set 0. The limit comes from a programmable register. Only its high byte is used, and the low byte is treated as zero. There is no recovery path after a fatal error.

All pins are plain control and status signals. The block has no data stream, so it has no valid/ready handshake and no back-pressure.

Top module: `kernel_stack_guard`

## Requirements
- R1: A write is checked only when `cpu_mode` is 2'b00 (kernel). With modes 2'b01, 2'b10 and 2'b11, neither `red_abort` nor `yellow_trap` is ever raised.
- R2: A write is checked only when `wr_en` is 1, `dst_reg` is 6 and `dst_mode` is one of 1, 2, 4 or 6. Modes 0, 3, 5 and 7, any other register, and cycles with `wr_en` at 0 are never classified.
- R3: When `cfg_strict` is 1, the check applies only while `rset_sel` is 0. When `cfg_strict` is 0, `rset_sel` has no effect.
- R4: The yellow boundary YB is `{stk_limit[15:8], 8'h00} + 16'h00FE`. The low byte of `stk_limit` is ignored. All comparisons are unsigned 16-bit. An address above YB is normal. An address at or below YB but above YB-32 is yellow. An address at or below YB-32 is red.
- R5: `red_abort` is combinational and is high in the same cycle as a qualified red write.
- R6: `emerg_req` is high for exactly the one cycle after each red write. While it is high, `emerg_sp` reads 16'd4 and `emerg_psw` reads 16'd0.
- R7: A red write never raises `yellow_trap`; red takes priority.
- R8: `yellow_trap` rises one cycle after a qualified yellow write. It stays high until a cycle in which `trap_ack` is 1, and it is low after that cycle unless the same cycle also carried a new yellow write.
- R9: An odd address is classified exactly like an even one. A red odd write still raises `red_abort`.
- R10: While `rst_n` is low and right after reset, `emerg_req` and `yellow_trap` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_strict | input | 1 | 1: check only in register set 0 |
| cpu_mode | input | 2 | Current processor mode, 2'b00 = kernel |
| rset_sel | input | 1 | Active register-set select bit |
| dst_mode | input | 3 | Destination addressing mode |
| dst_reg | input | 3 | Destination register number |
| wr_en | input | 1 | Data write strobe |
| wr_addr | input | 16 | Effective write address |
| stk_limit | input | 16 | Stack limit register (high byte used) |
| trap_ack | input | 1 | Clears the pending yellow trap |
| red_abort | output | 1 | Abort the current write (fatal stack error) |
| emerg_req | output | 1 | Emergency stack request, one cycle |
| emerg_sp | output | 16 | Stack pointer value to load (4) |
| emerg_psw | output | 16 | PSW placeholder to push (0) |
| yellow_trap | output | 1 | Pending yellow-zone trap request |

## Verification
`red_abort` belongs to the write cycle itself. The bench drives each write on a falling edge and samples the abort a short delay later, before the next rising edge. `emerg_req` and `yellow_trap` come out of one register stage, so they are sampled on the falling edge after the write. The bench then clears the pending trap with a one-cycle acknowledge before the next vector. Directed tests hold the yellow request over several idle cycles and overlap an acknowledge with a new yellow write, so the hold and set-over-clear rules are each checked at their own cycle.

// File: rtl/kslc_pkg.sv
package kslc_pkg;
  typedef enum logic [1:0] {
    ZN_NORMAL = 2'd0,
    ZN_YELLOW = 2'd1,
    ZN_RED    = 2'd2
  } zone_t;

  localparam logic [1:0] MODE_KERNEL = 2'b00;
endpackage

// File: rtl/kslc_qualify.sv
module kslc_qualify #(
  parameter int          RW          = 3,
  parameter int          SP_INDEX    = 6,
  parameter logic [7:0]  SP_MODE_SET = 8'b0101_0110
) (
  input  logic [1:0]    cpu_mode,
  input  logic          rset_sel,
  input  logic          cfg_strict,
  input  logic [RW-1:0] dst_mode,
  input  logic [RW-1:0] dst_reg,
  input  logic          wr_en,
  output logic          checked
);
  import kslc_pkg::*;
  localparam int NMODES = 1 << RW;

  logic [NMODES-1:0] mode_hit_vec;
  logic              mode_ok;
  logic              is_kernel;
  logic              is_sp;
  logic              rset_ok;

  for (genvar m = 0; m < NMODES; m++) begin : g_mode
    assign mode_hit_vec[m] = SP_MODE_SET[m] && (dst_mode == RW'(m));
  end

  always_comb begin
    mode_ok   = |mode_hit_vec;
    is_kernel = (cpu_mode == MODE_KERNEL);
    is_sp     = (dst_reg == RW'(SP_INDEX));
    rset_ok   = !cfg_strict || !rset_sel;
    checked   = wr_en && is_kernel && is_sp && mode_ok && rset_ok;
  end
endmodule

// File: rtl/kslc_zone.sv
module kslc_zone #(
  parameter int AW        = 16,
  parameter int KEEP_LSB  = 8,
  parameter int YEL_OFS   = 254,
  parameter int RED_WORDS = 16
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] limit,
  output kslc_pkg::zone_t zone
);
  import kslc_pkg::*;
  localparam int RED_BYTES = RED_WORDS * 2;

  logic [AW-1:0] base;
  logic [AW-1:0] yel_bnd;
  logic [AW-1:0] red_bnd;

  always_comb begin
    base    = {limit[AW-1:KEEP_LSB], {KEEP_LSB{1'b0}}};
    yel_bnd = base + AW'(YEL_OFS);
    red_bnd = yel_bnd - AW'(RED_BYTES);
    if (addr <= red_bnd)      zone = ZN_RED;
    else if (addr <= yel_bnd) zone = ZN_YELLOW;
    else                      zone = ZN_NORMAL;
  end
endmodule

// File: rtl/kslc_resp.sv
module kslc_resp (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            checked,
  input  kslc_pkg::zone_t zone,
  input  logic            trap_ack,
  output logic            red_abort,
  output logic            emerg_req,
  output logic            yellow_trap
);
  import kslc_pkg::*;
  logic red_now;
  logic yel_now;

  always_comb begin
    red_now   = checked && (zone == ZN_RED);
    yel_now   = checked && (zone == ZN_YELLOW);
    red_abort = red_now;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      emerg_req   <= 1'b0;
      yellow_trap <= 1'b0;
    end else begin
      emerg_req <= red_now;
      if (yel_now)       yellow_trap <= 1'b1;
      else if (trap_ack) yellow_trap <= 1'b0;
    end
  end
endmodule

// File: rtl/kernel_stack_guard.sv
module kernel_stack_guard #(
  parameter int AW        = 16,
  parameter int RW        = 3,
  parameter int KEEP_LSB  = 8,
  parameter int YEL_OFS   = 254,
  parameter int RED_WORDS = 16,
  parameter int EMERG_SP  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_strict,
  input  logic [1:0]    cpu_mode,
  input  logic          rset_sel,
  input  logic [RW-1:0] dst_mode,
  input  logic [RW-1:0] dst_reg,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [AW-1:0] stk_limit,
  input  logic          trap_ack,
  output logic          red_abort,
  output logic          emerg_req,
  output logic [AW-1:0] emerg_sp,
  output logic [AW-1:0] emerg_psw,
  output logic          yellow_trap
);
  import kslc_pkg::*;
  logic  checked;
  zone_t zone;

  kslc_qualify #(.RW(RW)) u_qual (
    .cpu_mode(cpu_mode), .rset_sel(rset_sel), .cfg_strict(cfg_strict),
    .dst_mode(dst_mode), .dst_reg(dst_reg), .wr_en(wr_en), .checked(checked)
  );

  kslc_zone #(.AW(AW), .KEEP_LSB(KEEP_LSB), .YEL_OFS(YEL_OFS),
              .RED_WORDS(RED_WORDS)) u_zone (
    .addr(wr_addr), .limit(stk_limit), .zone(zone)
  );

  kslc_resp u_resp (
    .clk(clk), .rst_n(rst_n), .checked(checked), .zone(zone),
    .trap_ack(trap_ack), .red_abort(red_abort), .emerg_req(emerg_req),
    .yellow_trap(yellow_trap)
  );

  assign emerg_sp  = AW'(EMERG_SP);
  assign emerg_psw = '0;
endmodule

// File: rtl/kernel_stack_guard_chk.sv
module kernel_stack_guard_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_strict,
  input logic [1:0]  cpu_mode,
  input logic        rset_sel,
  input logic [2:0]  dst_reg,
  input logic        wr_en,
  input logic        trap_ack,
  input logic        red_abort,
  input logic        emerg_req,
  input logic [15:0] emerg_sp,
  input logic [15:0] emerg_psw,
  input logic        yellow_trap
);
  a_r1_kernel_only: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_mode != 2'b00) |-> !red_abort);
  a_r2_sp_write_only: assert property (@(posedge clk) disable iff (!rst_n)
    red_abort |-> (wr_en && dst_reg == 3'd6));
  a_r3_strict_rset: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_strict && rset_sel) |-> !red_abort);
  a_r6_emerg_follows: assert property (@(posedge clk) disable iff (!rst_n)
    red_abort |=> emerg_req);
  a_r6_emerg_values: assert property (@(posedge clk) disable iff (!rst_n)
    emerg_req |-> (emerg_sp == 16'd4 && emerg_psw == 16'd0));
  a_r7_red_no_yellow: assert property (@(posedge clk) disable iff (!rst_n)
    (red_abort && !yellow_trap) |=> !yellow_trap);
  a_r8_yellow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (yellow_trap && !trap_ack) |=> yellow_trap);
endmodule

bind kernel_stack_guard kernel_stack_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_strict(cfg_strict), .cpu_mode(cpu_mode),
  .rset_sel(rset_sel), .dst_reg(dst_reg), .wr_en(wr_en), .trap_ack(trap_ack),
  .red_abort(red_abort), .emerg_req(emerg_req), .emerg_sp(emerg_sp),
  .emerg_psw(emerg_psw), .yellow_trap(yellow_trap)
);

// File: tb/tb_kernel_stack_guard.sv
module tb_kernel_stack_guard;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_strict;
  logic [1:0]  cpu_mode;
  logic        rset_sel;
  logic [2:0]  dst_mode;
  logic [2:0]  dst_reg;
  logic        wr_en;
  logic [15:0] wr_addr;
  logic [15:0] stk_limit;
  logic        trap_ack;
  logic        red_abort;
  logic        emerg_req;
  logic [15:0] emerg_sp;
  logic [15:0] emerg_psw;
  logic        yellow_trap;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  kernel_stack_guard dut (
    .clk(clk), .rst_n(rst_n), .cfg_strict(cfg_strict), .cpu_mode(cpu_mode),
    .rset_sel(rset_sel), .dst_mode(dst_mode), .dst_reg(dst_reg),
    .wr_en(wr_en), .wr_addr(wr_addr), .stk_limit(stk_limit),
    .trap_ack(trap_ack), .red_abort(red_abort), .emerg_req(emerg_req),
    .emerg_sp(emerg_sp), .emerg_psw(emerg_psw), .yellow_trap(yellow_trap)
  );

  // stim: strict, rset, mode, dmode, dreg, wr, addr, limit, exp_red, exp_yel
  typedef struct packed {
    logic        strict;
    logic        rset;
    logic [1:0]  mode;
    logic [2:0]  dmode;
    logic [2:0]  dreg;
    logic        wr;
    logic [15:0] addr;
    logic [15:0] lim;
    logic        red;
    logic        yel;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b0,2'd0,3'd4,3'd6,1'b1,16'h0500,16'h0400,1'b0,1'b0}, // R4 above YB
    '{1'b0,1'b0,2'd0,3'd4,3'd6,1'b1,16'h04FE,16'h0400,1'b0,1'b1}, // R4 at YB
    '{1'b0,1'b0,2'd0,3'd4,3'd6,1'b1,16'h04E0,16'h0400,1'b0,1'b1}, // R4 lowest yellow
    '{1'b0,1'b0,2'd0,3'd4,3'd6,1'b1,16'h04DE,16'h0400,1'b1,1'b0}, // R4 R7 top of red
    '{1'b0,1'b0,2'd0,3'd4,3'd6,1'b1,16'h0100,16'h0400,1'b1,1'b0}, // R5 deep red
    '{1'b0,1'b0,2'd3,3'd4,3'd6,1'b1,16'h0100,16'h0400,1'b0,1'b0}, // R1 user
    '{1'b0,1'b0,2'd1,3'd4,3'd6,1'b1,16'h04F0,16'h0400,1'b0,1'b0}, // R1 supervisor
    '{1'b0,1'b0,2'd0,3'd0,3'd6,1'b1,16'h0100,16'h0400,1'b0,1'b0}, // R2 mode 0
    '{1'b0,1'b0,2'd0,3'd3,3'd6,1'b1,16'h0100,16'h0400,1'b0,1'b0}, // R2 mode 3
    '{1'b0,1'b0,2'd0,3'd5,3'd6,1'b1,16'h0100,16'h0400,1'b0,1'b0}, // R2 mode 5
    '{1'b0,1'b0,2'd0,3'd7,3'd6,1'b1,16'h0100,16'h0400,1'b0,1'b0}, // R2 mode 7
    '{1'b0,1'b0,2'd0,3'd1,3'd6,1'b1,16'h0100,16'h0400,1'b1,1'b0}, // R2 mode 1
    '{1'b0,1'b0,2'd0,3'd2,3'd6,1'b1,16'h04F0,16'h0400,1'b0,1'b1}, // R2 mode 2
    '{1'b0,1'b0,2'd0,3'd6,3'd6,1'b1,16'h0100,16'h0400,1'b1,1'b0}, // R2 mode 6
    '{1'b0,1'b0,2'd0,3'd4,3'd5,1'b1,16'h0100,16'h0400,1'b0,1'b0}, // R2 reg 5
    '{1'b0,1'b0,2'd0,3'd4,3'd6,1'b0,16'h0100,16'h0400,1'b0,1'b0}, // R2 read
    '{1'b1,1'b1,2'd0,3'd4,3'd6,1'b1,16'h0100,16'h0400,1'b0,1'b0}, // R3 strict set1
    '{1'b1,1'b0,2'd0,3'd4,3'd6,1'b1,16'h0100,16'h0400,1'b1,1'b0}, // R3 strict set0
    '{1'b0,1'b1,2'd0,3'd4,3'd6,1'b1,16'h0100,16'h0400,1'b1,1'b0}, // R3 relaxed set1
    '{1'b0,1'b0,2'd0,3'd4,3'd6,1'b1,16'h04DD,16'h0400,1'b1,1'b0}, // R9 odd red
    '{1'b0,1'b0,2'd0,3'd4,3'd6,1'b1,16'h04FF,16'h0400,1'b0,1'b0}, // R9 odd above
    '{1'b0,1'b0,2'd0,3'd4,3'd6,1'b1,16'hFFF0,16'hFF37,1'b0,1'b1}, // R4 low byte
    '{1'b0,1'b0,2'd0,3'd4,3'd6,1'b1,16'h00DE,16'h0000,1'b1,1'b0}, // R4 zero lim red
    '{1'b0,1'b0,2'd0,3'd4,3'd6,1'b1,16'h00E0,16'h0000,1'b0,1'b1}  // R4 zero lim yel
  };

  task automatic chk(input bit ok, input string req, input longint act,
                     input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en    = 1'b0;
    trap_ack = 1'b0;
    cpu_mode = 2'd0;
    dst_mode = 3'd4;
    dst_reg  = 3'd6;
  endtask

  task automatic drive(input vec_t v);
    cfg_strict = v.strict;
    rset_sel   = v.rset;
    cpu_mode   = v.mode;
    dst_mode   = v.dmode;
    dst_reg    = v.dreg;
    wr_en      = v.wr;
    wr_addr    = v.addr;
    stk_limit  = v.lim;
  endtask

  task automatic clear_trap();
    @(negedge clk);
    idle();
    trap_ack = 1'b1;
    @(negedge clk);
    trap_ack = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    cfg_strict = 1'b0;
    rset_sel = 1'b0;
    wr_addr = 16'h0;
    stk_limit = 16'h0400;
    idle();
    repeat (3) @(negedge clk);
    chk(!emerg_req && !yellow_trap, "R10 reset state",
        {emerg_req, yellow_trap}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!emerg_req && !yellow_trap, "R10 after reset",
        {emerg_req, yellow_trap}, 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(TBL[i]);
      #1;
      chk(red_abort == TBL[i].red, $sformatf("R5 abort vec %0d", i),
          red_abort, TBL[i].red);
      @(negedge clk);
      idle();
      chk(emerg_req == TBL[i].red, $sformatf("R6 emerg vec %0d", i),
          emerg_req, TBL[i].red);
      chk(yellow_trap == TBL[i].yel, $sformatf("R8 R7 yellow vec %0d", i),
          yellow_trap, TBL[i].yel);
      if (TBL[i].red)
        chk(emerg_sp == 16'd4 && emerg_psw == 16'd0, "R6 emerg values",
            {emerg_sp, emerg_psw}, 32'h0004_0000);
      clear_trap();
      chk(!yellow_trap && !emerg_req, $sformatf("R8 R6 cleared vec %0d", i),
          {yellow_trap, emerg_req}, 0);
    end

    // R8: hold without acknowledge
    cfg_strict = 1'b0;
    rset_sel = 1'b0;
    stk_limit = 16'h0400;
    @(negedge clk);
    wr_en = 1'b1;
    wr_addr = 16'h04F0;
    @(negedge clk);
    idle();
    repeat (3) @(negedge clk);
    chk(yellow_trap, "R8 held without ack", yellow_trap, 1);
    // R8: acknowledge together with a new yellow write keeps it pending
    wr_en = 1'b1;
    wr_addr = 16'h04E2;
    trap_ack = 1'b1;
    @(negedge clk);
    idle();
    chk(yellow_trap, "R8 set over ack", yellow_trap, 1);
    // R7: red while pending leaves it pending, then emergency pulse is one cycle
    wr_en = 1'b1;
    wr_addr = 16'h0010;
    @(negedge clk);
    idle();
    chk(emerg_req && yellow_trap, "R7 red with pending",
        {emerg_req, yellow_trap}, 2'b11);
    @(negedge clk);
    chk(!emerg_req, "R6 single pulse", emerg_req, 0);
    trap_ack = 1'b1;
    @(negedge clk);
    trap_ack = 1'b0;
    chk(!yellow_trap, "R8 ack clears", yellow_trap, 0);

    // R10: reset drops a pending trap
    wr_en = 1'b1;
    wr_addr = 16'h04F0;
    @(negedge clk);
    idle();
    rst_n = 1'b0;
    @(negedge clk);
    chk(!yellow_trap && !emerg_req, "R10 reset clears pending",
        {yellow_trap, emerg_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule